// File: doc/BRIEF.md
# Bit-Reversed Post-Increment Address Generator

This block produces memory addresses for bit-reversed traversal of a buffer, the access order that reorders data for radix-2 FFT stages. It holds a 32-bit pointer and a 32-bit step value. The address it presents is formed from the current pointer. The upper 16 bits pass through unchanged. The lower 16 bits appear in mirrored order, so bit 0 swaps with bit 15, bit 1 with bit 14, and so on.

An access strobe marks a cycle in which that address is used. On the following clock edge, the pointer advances by the full step value in ordinary linear arithmetic. This makes it a post-increment: the address of an access always comes from the pointer as it was before the step. Software-visible registers, data memory and element-size scaling lie outside this block.

A load strobe writes a new pointer and a new step together. Take a buffer based on a 64 KiB boundary and a step of 0x2000. Successive accesses then land on byte offsets 0, 4, 2, 6, 1, 5, 3 and 7.

Top module: `brev_agu`

## Requirements
- R1: After reset the pointer and the step are zero, so `ptr_o` and `eff_addr_o` read 0.
- R2: `eff_addr_o[31:16]` always equals bits 31:16 of the current pointer.
- R3: `eff_addr_o[15:0]` is the bit-reversal of pointer bits 15:0, so that output bit i equals pointer bit 15-i. With a 64 KiB-based pointer and a step of 0x2000, successive offsets are 0, 4, 2, 6, 1, 5, 3, 7.
- R4: When `acc_i` is high and `ld_i` is low, `ptr_o` on the next cycle equals the previous pointer plus the full step value.
- R5: The address during an access cycle is formed from the pointer before that access's increment.
- R6: Pointer addition wraps modulo 2^32. For example, 0xFFFFE000 plus 0x2000 gives 0x00000000.
- R7: When `ld_i` and `acc_i` are high in the same cycle, the load wins. On the next cycle the pointer equals `ptr_init_i`, with no step added.
- R8: When neither strobe is high, the pointer and the step keep their values.
- R9: A load writes the pointer from `ptr_init_i` and the step from `step_init_i`. Later accesses use the new step.
- R10: A carry out of pointer bit 15 from a linear step appears in `eff_addr_o[31:16]`. For example, pointer 0x0001E000 plus 0x2000 gives upper half 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load pointer and step |
| ptr_init_i | input | 32 | Pointer value to load |
| step_init_i | input | 32 | Step value to load |
| acc_i | input | 1 | Access strobe; advances the pointer after this cycle |
| eff_addr_o | output | 32 | Effective address for the current access |
| ptr_o | output | 32 | Current (linear) pointer |

## Verification
The bench walks a full eight-access bit-reversed sweep with a step of 0x2000. A design that reverses the wrong number of bits, or that reverses the whole word, would give offsets other than 0, 4, 2, 6, 1, 5, 3, 7, or would corrupt the upper half. The sweep then crosses the 64 KiB boundary, which exposes a design that increments in the reversed domain: such a design never carries into bit 16. The bench also drives a load and an access in the same cycle, where a wrong priority would add the step to the freshly loaded pointer. Finally, it runs a step that wraps past 2^32 and an odd step, which catch a truncated adder and an address taken after the increment instead of before it.

// File: rtl/brev_agu_pkg.sv
package brev_agu_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } agu_op_e;

    // Load has priority over step.
    function automatic agu_op_e decode_op(input logic ld, input logic acc);
        if (ld)       return OP_LOAD;
        else if (acc) return OP_STEP;
        else          return OP_IDLE;
    endfunction

endpackage

// File: rtl/brev_agu_mirror.sv
module brev_agu_mirror #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign vec_o[i] = vec_i[W-1-i];
    end
endmodule

// File: rtl/brev_agu_state.sv
module brev_agu_state
    import brev_agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ptr_init_i,
    input  logic [ADDR_W-1:0] step_init_i,
    input  logic              acc_i,
    output logic [ADDR_W-1:0] ptr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] step;
    } state_t;

    state_t  st_d, st_q;
    agu_op_e op;

    always_comb begin
        op   = decode_op(ld_i, acc_i);
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.ptr  = ptr_init_i;
                st_d.step = step_init_i;
            end
            OP_STEP: st_d.ptr = st_q.ptr + st_q.step;  // wraps modulo 2^ADDR_W
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !ld_i) |=> (st_q.ptr == $past(st_q.ptr) + $past(st_q.step)));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (st_q.ptr == $past(ptr_init_i)) && (st_q.step == $past(step_init_i)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !acc_i) |=> $stable(st_q));

    assert_step_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(st_q.step));
endmodule

// File: rtl/brev_agu.sv
module brev_agu #(
    parameter int ADDR_W = 32,
    parameter int REV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ptr_init_i,
    input  logic [ADDR_W-1:0] step_init_i,
    input  logic              acc_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int HI_W = ADDR_W - REV_W;

    logic [ADDR_W-1:0] ptr_q;
    logic [REV_W-1:0]  low_rev;

    brev_agu_state #(.ADDR_W(ADDR_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (ld_i),
        .ptr_init_i (ptr_init_i),
        .step_init_i(step_init_i),
        .acc_i      (acc_i),
        .ptr_o      (ptr_q)
    );

    brev_agu_mirror #(.W(REV_W)) u_mirror (
        .vec_i(ptr_q[REV_W-1:0]),
        .vec_o(low_rev)
    );

    // Address comes from the pre-increment pointer (post-increment access).
    assign eff_addr_o = {ptr_q[ADDR_W-1:REV_W], low_rev};
    assign ptr_o      = ptr_q;

    // R3: mirror bit 0 of the pointer lands in the top of the reversed field.
    assert_mirror_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr_o[REV_W-1] == ptr_o[0]) && (eff_addr_o[0] == ptr_o[REV_W-1]));

    // R10: a step whose low half is zero leaves the reversed field unchanged.
    assert_low_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !ld_i && $past(ld_i) == 1'b0 && u_state.st_q.step[REV_W-1:0] == '0)
        |=> $stable(eff_addr_o[REV_W-1:0]));

    if (HI_W < 1) begin : g_bad_cfg
        initial $error("REV_W must be below ADDR_W");
    end
endmodule

// File: tb/tb_brev_agu.sv
`timescale 1ns/1ps
module tb_brev_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_i = 1'b0;
    logic        acc_i = 1'b0;
    logic [31:0] ptr_init_i = '0;
    logic [31:0] step_init_i = '0;
    logic [31:0] eff_addr_o, ptr_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] ptr_m = '0;
    logic [31:0] step_m = '0;
    logic [31:0] exp_ptr_q[$];
    string       exp_tag_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    brev_agu dut (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ptr_init_i(ptr_init_i),
        .step_init_i(step_init_i), .acc_i(acc_i),
        .eff_addr_o(eff_addr_o), .ptr_o(ptr_o)
    );

    function automatic logic [31:0] model_ea(input logic [31:0] p);
        logic [31:0] r;
        r[31:16] = p[31:16];
        for (int i = 0; i < 16; i++) r[15 - i] = p[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks the address, queues the pointer.
    task automatic drive(input bit ld, input bit acc, input logic [31:0] p,
                         input logic [31:0] s, input string tag);
        @(negedge clk);
        ld_i = ld; acc_i = acc; ptr_init_i = p; step_init_i = s;
        #2;
        check({tag, " addr (R5 pre-increment)"}, eff_addr_o, model_ea(ptr_m));
        if (ld) begin ptr_m = p; step_m = s; end
        else if (acc) ptr_m = ptr_m + step_m;
        exp_ptr_q.push_back(ptr_m);
        exp_tag_q.push_back(tag);
    endtask

    // Monitor: compares the registered pointer one cycle later.
    always @(negedge clk) begin
        #1;
        if (exp_ptr_q.size() > 0) begin
            string t;
            logic [31:0] e;
            e = exp_ptr_q.pop_front();
            t = exp_tag_q.pop_front();
            check({t, " ptr"}, ptr_o, e);
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset ptr", ptr_o, 32'h0);
        check("R1 reset addr", eff_addr_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 0, 32'h0001_0000, 32'h0000_2000, "R9 load");
        begin
            logic [15:0] offs [8] = '{16'd0, 16'd4, 16'd2, 16'd6, 16'd1, 16'd5, 16'd3, 16'd7};
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                ld_i = 0; acc_i = 0;
                #2;
                check("R3 reversed offset", {16'h0, eff_addr_o[15:0]}, {16'h0, offs[k]});
                check("R2 upper half", {16'h0, eff_addr_o[31:16]}, 32'h0000_0001);
                drive(0, 1, 32'hDEAD_BEEF, 32'h1234_5678, "R4 step");
            end
        end
        @(negedge clk);
        ld_i = 0; acc_i = 0;
        #2;
        check("R10 carry into upper", eff_addr_o, 32'h0002_0000);

        drive(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 idle");
        drive(0, 0, 32'h0F0F_0F0F, 32'h1, "R8 idle");
        drive(1, 1, 32'h1234_5678, 32'h0000_0001, "R7 load beats access");
        drive(0, 1, 32'h0, 32'h0, "R9 new step used");
        drive(1, 0, 32'hFFFF_E000, 32'h0000_2000, "R9 load");
        @(negedge clk);
        ld_i = 0; acc_i = 0;
        #2;
        check("R5 addr before wrap", eff_addr_o, 32'hFFFF_0007);
        drive(0, 1, 32'h0, 32'h0, "R6 wrap");
        drive(0, 0, 32'h0, 32'h0, "R6 after wrap");
        drive(1, 0, 32'h0000_8001, 32'h0001_0003, "R9 odd step");
        drive(0, 1, 32'h0, 32'h0, "R4 odd step");
        drive(0, 1, 32'h0, 32'h0, "R4 odd step");
        drive(0, 0, 32'h0, 32'h0, "R8 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule